// File: doc/BRIEF.md
# Transmit Buffer with Burst-Room and Start Thresholds

This block sits between a host bus writer and a network transmitter. The host pushes data words over a valid/ready stream. Each word carries a flag that marks the final word of a packet. Two programmable levels govern the block's behaviour. The first is a burst size: the host may start a write burst only while the free space is at least that size. The second is a start level: the transmitter is asked to begin once that many words are queued.

A stored end-of-packet also raises the start request, whatever the count. This lets a short packet go out without reaching the start level. Once a packet has begun, the start request holds until that packet's final word has been read. If the transmitter asks for a word during a packet and the buffer is empty, a sticky underrun bit is set. No word is removed on that request. A write-one pulse clears the bit.

Both streams follow valid/ready rules. A word moves only in a cycle where valid and ready are both high. The host side sees ready low only when the buffer is full. The transmitter sees valid only while a start request is active and a word is present. While either side holds its signal high and the other holds back, nothing moves.

Top module: `tx_start_fifo`

## Requirements
- R1: After reset the buffer is empty: `wr_ready`=1, `rd_valid`=0, `tx_start`=0, `err_underrun`=0, and `buf_avail`=1 for any `burst_size` up to DEPTH.
- R2: `buf_avail` is 1 exactly when (DEPTH − stored words) ≥ `burst_size`.
- R3: `wr_ready` is 0 only when DEPTH words are stored. A word is taken only when `wr_valid` and `wr_ready` are both 1. Words and their last flags leave in the order they were written, and no more than DEPTH words are ever held.
- R4: With no end-of-packet stored, `tx_start` rises once the stored count reaches `start_level`. A `start_level` of 0 acts as 1.
- R5: While at least one word with its last flag set is stored, `tx_start` is 1 regardless of the count.
- R6: Once `tx_start` has risen, it stays 1 until a word with the last flag set is read, even if the count falls below `start_level`.
- R7: `rd_valid` equals `tx_start` AND (buffer not empty). A word is removed only when `rd_valid` and `rd_ready` are both 1.
- R8: `rd_ready`=1 with an empty buffer while a packet is in progress sets `err_underrun` on the next edge. No word is removed, and the bit stays set.
- R9: An `err_clear` pulse clears `err_underrun` on the next edge. If a new underrun occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host word valid |
| wr_ready | output | 1 | Buffer can take a word |
| wr_data | input | DATA_W | Host data word |
| wr_last | input | 1 | Word is the final word of its packet |
| burst_size | input | CW | Free entries required for `buf_avail` |
| buf_avail | output | 1 | Room for a whole host burst |
| start_level | input | CW | Stored-word count that starts transmission |
| tx_start | output | 1 | Request to the transmitter to send |
| rd_valid | output | 1 | Word offered to the transmitter |
| rd_ready | input | 1 | Transmitter takes or requests a word |
| rd_data | output | DATA_W | Word at the head |
| rd_last | output | 1 | Head word ends its packet |
| err_clear | input | 1 | Write-one-to-clear for the underrun bit |
| err_underrun | output | 1 | Sticky transmit underrun |

## Verification
The bench drives the buffer to exactly DEPTH−burst_size words and then one more. A design with an off-by-one room comparison would flip `buf_avail` one word early or late. It fills the buffer completely and offers one extra word. A design that ignores `wr_ready` would corrupt the scoreboard's order or lose the final last flag.

It drains a started packet below the start level. A design that recomputes the start from the count alone would drop `tx_start` and stall the packet. It also sends a three-word packet under a high start level. A design that ignores stored end-of-packet markers would never start.

Underrun is raised in the same cycle as a clear. This catches a design where the clear has priority. The bench also checks that a read on an empty buffer removes nothing.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_phase_t;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DATA_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {push_last, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
    end
  end

  assign {head_last, head_data} = mem[rptr];
endmodule

// File: rtl/tsf_level.sv
module tsf_level #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_last,
  input  logic          pop,
  input  logic          pop_last,
  output logic [CW-1:0] count,
  output logic [CW-1:0] eop_cnt
);
  logic [CW-1:0] cnt_q, eop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eop_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      eop_q <= eop_q + CW'(push && push_last) - CW'(pop && pop_last);
    end
  end

  assign count   = cnt_q;
  assign eop_cnt = eop_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R3
  AST_EOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eop_q <= cnt_q); // R5
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] eop_cnt,
  input  logic [CW-1:0] start_level,
  input  logic          pop,
  input  logic          pop_last,
  input  logic          rd_ready,
  input  logic          err_clear,
  output logic          tx_start,
  output logic          err_underrun
);
  tx_phase_t     phase_q;
  logic [CW-1:0] lvl_eff;
  logic          start_cond, hit;
  logic          err_q;

  assign lvl_eff    = (start_level == '0) ? CW'(1) : start_level;
  assign start_cond = (count >= lvl_eff) || (eop_cnt != '0);
  assign hit        = (phase_q == TX_SEND) && rd_ready && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (pop && pop_last)  phase_q <= TX_IDLE;
      else if (start_cond)  phase_q <= TX_SEND;
      if (hit)              err_q <= 1'b1;
      else if (err_clear)   err_q <= 1'b0;
    end
  end

  assign tx_start     = (phase_q == TX_SEND) || start_cond;
  assign err_underrun = err_q;

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !(pop && pop_last)) |=> tx_start); // R6
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && rd_ready && count == '0) |=> err_underrun); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underrun && !err_clear) |=> err_underrun); // R9
endmodule

// File: rtl/tx_start_fifo.sv
module tx_start_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic [CW-1:0]     burst_size,
  output logic              buf_avail,
  input  logic [CW-1:0]     start_level,
  output logic              tx_start,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  input  logic              err_clear,
  output logic              err_underrun
);
  logic [CW-1:0] count, eop_cnt, free_cnt;
  logic          push, pop;

  assign wr_ready  = (count != CW'(DEPTH));
  assign push      = wr_valid && wr_ready;
  assign rd_valid  = tx_start && (count != '0);
  assign pop       = rd_valid && rd_ready;
  assign free_cnt  = CW'(DEPTH) - count;
  assign buf_avail = (free_cnt >= burst_size);

  tsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .push_last(wr_last), .pop(pop), .head_data(rd_data), .head_last(rd_last)
  );

  tsf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push), .push_last(wr_last),
    .pop(pop), .pop_last(rd_last), .count(count), .eop_cnt(eop_cnt)
  );

  tsf_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .count(count), .eop_cnt(eop_cnt),
    .start_level(start_level), .pop(pop), .pop_last(rd_last),
    .rd_ready(rd_ready), .err_clear(err_clear),
    .tx_start(tx_start), .err_underrun(err_underrun)
  );

  AST_EOP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_cnt != '0) |-> tx_start); // R5
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |=> (count <= CW'(DEPTH))); // R3
endmodule

// File: tb/tx_start_fifo_test.sv
module tx_start_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 32;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, rd_ready = 1'b0, err_clear = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CW-1:0] burst_size = CW'(8), start_level = CW'(6);
  logic wr_ready, buf_avail, tx_start, rd_valid, rd_last, err_underrun;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [DATA_W:0] sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_start_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .burst_size(burst_size),
    .buf_avail(buf_avail), .start_level(start_level), .tx_start(tx_start),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .err_clear(err_clear), .err_underrun(err_underrun)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic [DATA_W-1:0] d, input logic l,
                       input logic rr, input logic ec);
    @(negedge clk);
    wr_valid = wv; wr_data = d; wr_last = l; rd_ready = rr; err_clear = ec;
    #1;
    if (wv && wr_ready) sb.push_back({l, d});
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic put(input logic [DATA_W-1:0] d, input logic l);
    drive(1'b1, d, l, 1'b0, 1'b0);
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
  endtask

  // Monitor: compares each word taken by the transmitter against the scoreboard (R3, R7)
  always @(posedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 pop with empty scoreboard", 1, 0);
      end else begin
        logic [DATA_W:0] e;
        e = sb.pop_front();
        chk({rd_last, rd_data} == e, "R3 order/data", int'(rd_data), int'(e[DATA_W-1:0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    chk(buf_avail == 1, "R1 buf_avail", buf_avail, 1);
    chk(tx_start == 0, "R1 tx_start", tx_start, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(err_underrun == 0, "R1 err", err_underrun, 0);

    // R4: threshold start at 6 words
    for (int i = 0; i < 5; i++) put(32'h100 + i, 1'b0);
    idle();
    chk(tx_start == 0, "R4 below level", tx_start, 0);
    chk(rd_valid == 0, "R7 no valid before start", rd_valid, 0);
    put(32'h105, 1'b0);
    idle();
    chk(tx_start == 1, "R4 at level", tx_start, 1);

    // R6: drain below level, start holds; then R8 underrun
    take(6);
    idle();
    chk(tx_start == 1, "R6 hold after drain", tx_start, 1);
    chk(sb.size() == 0, "R7 all six read", sb.size(), 0);
    take(1);
    idle();
    chk(err_underrun == 1, "R8 underrun set", err_underrun, 1);
    put(32'h1FF, 1'b1);
    idle();
    chk(sb.size() == 1, "R8 nothing popped on empty read", sb.size(), 1);
    take(1);
    idle();
    chk(tx_start == 0, "R6 drop after last read", tx_start, 0);
    chk(err_underrun == 1, "R8 sticky", err_underrun, 1);

    // R9 clear, and set-wins
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1);
    idle();
    chk(err_underrun == 0, "R9 cleared", err_underrun, 0);
    for (int i = 0; i < 6; i++) put(32'h200 + i, 1'b0);
    take(6);
    drive(1'b0, '0, 1'b0, 1'b1, 1'b1);
    idle();
    chk(err_underrun == 1, "R9 set wins over clear", err_underrun, 1);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1);
    put(32'h2FF, 1'b1);
    idle();
    chk(err_underrun == 0, "R9 clear alone", err_underrun, 0);
    take(1);
    idle();

    // R5: short packet under a high start level
    start_level = CW'(20);
    put(32'h300, 1'b0);
    put(32'h301, 1'b0);
    idle();
    chk(tx_start == 0, "R5 no start before eop", tx_start, 0);
    put(32'h302, 1'b1);
    idle();
    chk(tx_start == 1, "R5 eop starts", tx_start, 1);
    chk(rd_valid == 1, "R7 valid on start", rd_valid, 1);
    take(3);
    idle();
    chk(tx_start == 0, "R6 packet done", tx_start, 0);

    // R2/R3: room threshold and full
    start_level = CW'(0);
    for (int i = 0; i < 24; i++) put(32'h400 + i, 1'b0);
    idle();
    chk(buf_avail == 1, "R2 free equals burst", buf_avail, 1);
    chk(tx_start == 1, "R4 level 0 acts as 1", tx_start, 1);
    put(32'h418, 1'b0);
    idle();
    chk(buf_avail == 0, "R2 free below burst", buf_avail, 0);
    for (int i = 25; i < 32; i++) put(32'h400 + i, i == 31);
    idle();
    chk(wr_ready == 0, "R3 full", wr_ready, 0);
    put(32'hDEAD, 1'b0);
    idle();
    chk(wr_ready == 0, "R3 full ignores write", wr_ready, 0);
    take(32);
    idle();
    chk(sb.size() == 0, "R3 all words out", sb.size(), 0);
    chk(rd_valid == 0, "R7 empty no valid", rd_valid, 0);
    chk(tx_start == 0, "R6 done after last", tx_start, 0);
    chk(wr_ready == 1, "R3 ready after drain", wr_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule